// File: doc/BRIEF.md
# Adaptive Block-Format Dot-Product Accumulator

This unit multiplies two blocks of sixteen 4-bit codes and adds the result into a running signed fixed-point accumulator. Each block comes with an 8-bit scale. The top bit of that scale byte acts as a format flag and is not a sign. When the flag is clear, the block's codes are read as small floats with one sign bit, two exponent bits and one mantissa bit. When it is set, the codes are read as two's-complement integers multiplied by 6/7. The remaining seven bits of the scale hold an unsigned 4-bit-exponent, 3-mantissa-bit scale factor with an exponent bias of 7.

Both blocks are decoded into one shared fixed-point element form. The sixteen pairs go through one multiplier tree and one adder tree. The sum is then multiplied by the product of the two scale significands, shifted by the combined scale exponent, and added into the accumulator with saturation. A new block pair can be presented on every clock. Each block pair reaches the accumulator a fixed two cycles after it is accepted.

Top module: `ablk_mac`

## Requirements
- R1: After reset the accumulator output reads zero.
- R2: With scale bit 7 clear, code bits [2:0] give the magnitude 0, 0.5, 1, 1.5, 2, 3, 4 or 6, and code bit 3 negates it. Element i sits in code bits [4i+3:4i].
- R3: With scale bit 7 set, a code is a signed 4-bit integer q in the range -8..7 whose value is q*55/64, the 6/7 factor rounded to 6 fraction bits.
- R4: The format flag of each operand is applied only to that operand's block, so float×integer and integer×float pairs both decode correctly.
- R5: Scale bits [6:3]=e and [2:0]=m give (8+m)*2^(e-10) when e>0 and m*2^-9 when e=0. Bit 7 does not change the scale value, and magnitude 0x7F is an ordinary number.
- R6: A scale magnitude of zero on either operand adds nothing to the accumulator, whatever the codes are.
- R7: A block pair accepted with in_valid at clock edge k changes the accumulator at edge k+2, and a pair may be accepted on every edge.
- R8: When acc_clr is high at an edge, the accumulator loads the contribution arriving at that edge, or zero if none arrives.
- R9: The accumulator saturates at the most positive and the most negative 64-bit values instead of wrapping around.
- R10: While in_valid is low, the codes and scales are ignored and the accumulator holds its value.
- R11: The accumulator LSB weighs 2^-30, so every contribution is added exactly with no rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the block pair on this edge |
| acc_clr | input | 1 | Restart the accumulator at this edge |
| a_codes | input | 64 | Sixteen 4-bit codes of operand A |
| a_scale | input | 8 | Format flag and scale of operand A |
| b_codes | input | 64 | Sixteen 4-bit codes of operand B |
| b_scale | input | 8 | Format flag and scale of operand B |
| acc | output | 64 | Signed accumulator, LSB = 2^-30 |

## Verification
The hardest condition to reach from the ports is saturation. Only the largest scale magnitudes together with all-maximum codes move the accumulator close to its limit, and even then it takes dozens of block pairs. The stimulus therefore applies about eighty maximum positive blocks and then a longer run of maximum negative blocks, so the accumulator pins at both ends. A second corner is a clear arriving at the same edge as an in-flight result. A directed sequence times acc_clr two cycles after a valid block so that the two coincide.

// File: rtl/ablk_mac.sv
module ablk_mac #(
  parameter int N      = 16,
  parameter int FRAC_W = 6,
  parameter int ACC_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    acc_clr,
  input  logic [4*N-1:0]          a_codes,
  input  logic [7:0]              a_scale,
  input  logic [4*N-1:0]          b_codes,
  input  logic [7:0]              b_scale,
  output logic signed [ACC_W-1:0] acc
);
  localparam int EL_W   = FRAC_W + 4;
  localparam int K_INT  = (12 * (2 ** FRAC_W) + 7) / 14;
  localparam int SUM_W  = 2 * EL_W + $clog2(N) + 1;
  localparam int PROD_W = SUM_W + 9;
  localparam int TERM_W = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic signed [EL_W-1:0] dec_elem(input logic [3:0] c, input logic int_mode);
    logic [3:0] halves;
    logic signed [EL_W-1:0] mag;
    int q;
    if (int_mode) begin
      q = $signed(c) * K_INT;
      return EL_W'(q);
    end
    case (c[2:0])
      3'd0: halves = 4'd0;
      3'd1: halves = 4'd1;
      3'd2: halves = 4'd2;
      3'd3: halves = 4'd3;
      3'd4: halves = 4'd4;
      3'd5: halves = 4'd6;
      3'd6: halves = 4'd8;
      default: halves = 4'd12;
    endcase
    mag = EL_W'(halves) <<< (FRAC_W - 1);
    return c[3] ? -mag : mag;
  endfunction

  function automatic logic [3:0] sig_of(input logic [7:0] s);
    return (s[6:3] == 4'd0) ? {1'b0, s[2:0]} : {1'b1, s[2:0]};
  endfunction

  function automatic logic [3:0] exp_of(input logic [7:0] s);
    return (s[6:3] == 4'd0) ? 4'd1 : s[6:3];
  endfunction

  // stage 1: per-block decode (lookup for float, constant multiply for integer)
  logic signed [EL_W-1:0] a_el [N];
  logic signed [EL_W-1:0] b_el [N];
  logic [3:0] sa_q, sb_q, ea_q, eb_q;
  logic v1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        a_el[i] <= '0;
        b_el[i] <= '0;
      end
      sa_q <= '0; sb_q <= '0; ea_q <= 4'd1; eb_q <= 4'd1;
      v1 <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        for (int i = 0; i < N; i++) begin
          a_el[i] <= dec_elem(a_codes[4*i +: 4], a_scale[7]);
          b_el[i] <= dec_elem(b_codes[4*i +: 4], b_scale[7]);
        end
        sa_q <= sig_of(a_scale);
        sb_q <= sig_of(b_scale);
        ea_q <= exp_of(a_scale);
        eb_q <= exp_of(b_scale);
      end
    end
  end

  // stage 2: shared multiplier and adder tree, combined scale
  logic signed [2*EL_W-1:0] prod [N];
  logic signed [SUM_W-1:0]  dot;

  for (genvar g = 0; g < N; g++) begin : g_mul
    assign prod[g] = a_el[g] * b_el[g];
  end

  always_comb begin
    dot = '0;
    for (int i = 0; i < N; i++) dot = dot + SUM_W'(prod[i]);
  end

  logic signed [SUM_W-1:0] dot_q;
  logic [7:0] sp_q;
  logic [4:0] sh_q;
  logic v2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dot_q <= '0; sp_q <= '0; sh_q <= '0; v2 <= 1'b0;
    end else begin
      v2 <= v1;
      if (v1) begin
        dot_q <= dot;
        sp_q  <= {4'd0, sa_q} * {4'd0, sb_q};
        sh_q  <= {1'b0, ea_q} + {1'b0, eb_q} - 5'd2;
      end
    end
  end

  // stage 3: scaling and saturating accumulation
  logic signed [PROD_W-1:0] scaled;
  logic signed [TERM_W-1:0] term, base, nxt;

  assign scaled = dot_q * $signed({1'b0, sp_q});
  assign term   = TERM_W'(scaled) <<< sh_q;
  assign base   = acc_clr ? '0 : TERM_W'(acc);
  assign nxt    = base + (v2 ? term : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (nxt[TERM_W-1] != nxt[TERM_W-2]) acc <= nxt[TERM_W-1] ? ACC_MIN : ACC_MAX;
    else acc <= nxt[ACC_W-1:0];
  end

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr && !v2 |=> acc == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clr && !v2 |=> $stable(acc));

  p_zero_scale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    v1 && (sa_q == 4'd0 || sb_q == 4'd0) |=> v2 && term == '0);

  p_sat_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clr && v2 && !term[TERM_W-1] |=> acc >= $past(acc));

  p_sat_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_clr && v2 && term[TERM_W-1] |=> acc <= $past(acc));
endmodule

// File: tb/ablk_mac_bench.sv
`timescale 1ns/1ps
module ablk_mac_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, acc_clr;
  logic [63:0] a_codes, b_codes;
  logic [7:0]  a_scale, b_scale;
  logic signed [63:0] acc;

  always #4 clk = ~clk;

  ablk_mac u_ablk_mac (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .acc_clr(acc_clr),
    .a_codes(a_codes), .a_scale(a_scale), .b_codes(b_codes), .b_scale(b_scale),
    .acc(acc)
  );

  localparam logic signed [65:0] AMAX = (66'sd1 <<< 63) - 66'sd1;
  localparam logic signed [65:0] AMIN = -(66'sd1 <<< 63);

  int tests = 0, fails = 0;
  bit done = 0;
  logic signed [65:0] exp_acc, mt0, mt1;
  bit mv0, mv1;

  function automatic longint elem_val(input logic [3:0] c, input bit im);
    longint h;
    if (im) return longint'($signed(c)) * 55;
    case (c[2:0])
      3'd0: h = 0; 3'd1: h = 1; 3'd2: h = 2; 3'd3: h = 3;
      3'd4: h = 4; 3'd5: h = 6; 3'd6: h = 8; default: h = 12;
    endcase
    return c[3] ? -(h * 32) : h * 32;
  endfunction

  function automatic logic signed [65:0] blk_term(input logic [63:0] ac, input logic [7:0] as,
                                                  input logic [63:0] bc, input logic [7:0] bs);
    longint dot = 0;
    longint sa, sb;
    int ea, eb;
    logic signed [65:0] t;
    for (int i = 0; i < 16; i++)
      dot += elem_val(ac[4*i +: 4], as[7]) * elem_val(bc[4*i +: 4], bs[7]);
    sa = (as[6:3] == 0) ? longint'(as[2:0]) : 8 + longint'(as[2:0]);
    sb = (bs[6:3] == 0) ? longint'(bs[2:0]) : 8 + longint'(bs[2:0]);
    ea = (as[6:3] == 0) ? 1 : int'(as[6:3]);
    eb = (bs[6:3] == 0) ? 1 : int'(bs[6:3]);
    t = 66'(dot * sa * sb);
    return t <<< (ea + eb - 2);
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] expv, input string tag);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: acc=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input bit v, input bit c, input logic [63:0] ac, input logic [7:0] as,
                      input logic [63:0] bc, input logic [7:0] bs, input string tag);
    logic signed [65:0] t, n;
    in_valid = v; acc_clr = c; a_codes = ac; a_scale = as; b_codes = bc; b_scale = bs;
    t = blk_term(ac, as, bc, bs);
    @(posedge clk);
    n = (c ? 66'sd0 : exp_acc) + (mv1 ? mt1 : 66'sd0);
    if (n > AMAX) n = AMAX;
    if (n < AMIN) n = AMIN;
    exp_acc = n;
    mv1 = mv0; mt1 = mt0; mv0 = v; mt0 = t;
    @(negedge clk);
    chk(acc, exp_acc[63:0], tag);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, rnd64(), 8'($urandom), rnd64(), 8'($urandom), tag);
  endtask

  function automatic logic [63:0] fill(input logic [3:0] c);
    return {16{c}};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: acc=%h expected=finish", acc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] seq;
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; acc_clr = 0;
    a_codes = '0; b_codes = '0; a_scale = '0; b_scale = '0;
    exp_acc = 0; mt0 = 0; mt1 = 0; mv0 = 0; mv1 = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(acc, 64'd0, "R1");

    // R2: every float code against 1.0
    for (int c = 0; c < 16; c++) begin
      step(1, 0, fill(4'(c)), 8'h38, fill(4'h2), 8'h38, "R2");
      idle(2, "R2");
    end
    step(0, 1, '0, 8'h00, '0, 8'h00, "R8");
    // R3: every integer code against 1.0
    for (int c = 0; c < 16; c++) begin
      step(1, 0, fill(4'(c)), 8'hB8, fill(4'h2), 8'h38, "R3");
      idle(2, "R3");
    end
    // R4: mixed formats with distinct per-element codes
    for (int i = 0; i < 16; i++) seq[4*i +: 4] = 4'(i);
    step(1, 0, seq, 8'h38, seq, 8'hB8, "R4");
    step(1, 0, seq, 8'hB8, seq, 8'h38, "R4");
    step(1, 0, seq, 8'hB8, ~seq, 8'hB8, "R4");
    idle(3, "R4");
    // R7: single block, check before and at arrival
    step(1, 1, fill(4'h3), 8'h40, fill(4'hD), 8'h30, "R7");
    step(0, 0, '0, 8'h00, '0, 8'h00, "R7");
    step(0, 0, '0, 8'h00, '0, 8'h00, "R7");
    // R5: subnormal and extreme scales, sign bit as flag only
    for (int m = 0; m < 8; m++) begin
      step(1, 0, fill(4'h7), {1'b0, 4'd0, 3'(m)}, fill(4'h5), 8'h7F, "R5");
      step(1, 0, fill(4'h1), {1'b1, 4'd0, 3'(m)}, fill(4'hC), {1'b0, 4'd15, 3'(m)}, "R5");
    end
    idle(3, "R5");
    // R6: zero-magnitude scales
    for (int i = 0; i < 6; i++) begin
      step(1, 0, rnd64(), 8'h00, rnd64(), 8'($urandom), "R6");
      step(1, 0, rnd64(), 8'($urandom), rnd64(), 8'h80, "R6");
    end
    idle(3, "R6");
    // R10: garbage while invalid
    idle(10, "R10");
    // R8: clear colliding with an arriving result
    step(1, 0, fill(4'h6), 8'h48, fill(4'h6), 8'h48, "R8");
    step(0, 0, rnd64(), 8'hFF, rnd64(), 8'hFF, "R8");
    step(0, 1, rnd64(), 8'hFF, rnd64(), 8'hFF, "R8");
    step(0, 1, '0, 8'h00, '0, 8'h00, "R8");
    // R9: saturation at both ends
    for (int i = 0; i < 80; i++) step(1, 0, fill(4'h7), 8'h7F, fill(4'h7), 8'h7F, "R9");
    idle(3, "R9");
    chk(acc, AMAX[63:0], "R9");
    for (int i = 0; i < 150; i++) step(1, 0, fill(4'hF), 8'h7F, fill(4'h7), 8'h7F, "R9");
    idle(3, "R9");
    chk(acc, AMIN[63:0], "R9");
    step(1, 1, fill(4'h2), 8'h38, fill(4'h2), 8'h38, "R11");
    idle(3, "R11");
    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 10) < 7, ($urandom % 64) == 0, rnd64(), 8'($urandom),
           rnd64(), 8'($urandom), "R4");
    idle(3, "R11");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule